// File: doc/BRIEF.md
# Multiplexed-Strobe to Static-RAM Bridge

This block sits between a memory controller that still speaks multiplexed dynamic-memory signalling and a static RAM. The controller puts the row half of an address on a narrow bus and raises a row strobe. It then puts the column half on the same bus and raises a column strobe. The bridge captures both halves and drives the full static-RAM address. It also generates a chip enable and a write enable, and keeps the last read byte on a holding output.

An input marks which half of each system cycle is running. In the processor half, a parameter sets how many strobe sequences are served. The default is two, which allows two back-to-back fast accesses. In the video half a second parameter sets the limit, and only reads are served. A row strobe that is not followed by a column strobe is a refresh. It is absorbed and never reaches the static RAM. A region-select input tells the bridge that ROM or I/O is mapped over the address. While it is high, the bridge keeps the RAM disabled.

All strobes and enables are active-high and are sampled on the fast clock. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `dram_sram_bridge`

## Requirements
- R1: While reset is held and for the synchroniser cycles after its release, `sram_ce`, `sram_we` and `rd_data` are all zero.
- R2: A rising edge of `row_stb` loads `addr_mux` into the low byte of `sram_addr`. A rising edge of `col_stb` loads `addr_mux` into the high byte, so `sram_addr` = {column, row}.
- R3: A rising edge of `col_stb` while `row_stb` is high is a granted access. `sram_ce` goes high on the next cycle and stays high until `col_stb` is sampled low.
- R4: A row strobe with no column strobe is a refresh. It never raises `sram_ce`, it uses up no access slot, and it leaves `rd_data` unchanged.
- R5: If `region_sel` is high when the column edge arrives, `sram_ce` stays low and no slot is used up.
- R6: A granted processor-half access with `we_req` high drives `sram_we` high for exactly one cycle, the first cycle of `sram_ce`. At that point the column byte is already in `sram_addr`.
- R7: On a granted read, `rd_data` takes the value of `sram_rdata` one cycle after `sram_ce` rises. It then holds that value until the next read capture.
- R8: In the processor half (`half_cpu`=1), at most CPU_SLOTS accesses are granted. Any further column edge in the same half leaves `sram_ce` low.
- R9: In the video half (`half_cpu`=0), at most VID_SLOTS accesses are granted. `we_req` is ignored there, so a video access is always a read and stored data is not changed.
- R10: Any change of `half_cpu` restores the full slot allowance for the new half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_cpu | input | 1 | 1 = processor half, 0 = video half |
| row_stb | input | 1 | Row strobe, active-high |
| col_stb | input | 1 | Column strobe, active-high |
| addr_mux | input | MUX_W | Multiplexed address bus |
| we_req | input | 1 | Write request that goes with the strobes |
| region_sel | input | 1 | ROM/I/O mapped over the address; suppresses the RAM |
| sram_rdata | input | DW | Read data from the static RAM |
| sram_addr | output | 2*MUX_W | Full static-RAM address |
| sram_ce | output | 1 | Static-RAM chip enable |
| sram_we | output | 1 | Static-RAM write enable |
| rd_data | output | DW | Held read data |

## Verification
The bench uses the default build: an 8-bit multiplexed bus, a 16-bit address, two processor slots and one video slot. With slot limits this small, a third strobe sequence in a processor half, or a second one in a video half, is enough to reach the denial paths. The corner addresses 0x0000 and 0xFFFF test both latches at their extremes. A video-half write attempt followed by a processor-half readback shows that the stored byte was left unchanged.

// File: rtl/dram_sram_pkg.sv
package dram_sram_pkg;
  typedef enum logic {HALF_VID = 1'b0, HALF_CPU = 1'b1} half_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~prev_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
  end
endmodule

// File: rtl/addr_demux.sv
module addr_demux #(
  parameter int MUX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_rise,
  input  logic               col_rise,
  input  logic [MUX_W-1:0]   addr_mux,
  output logic [2*MUX_W-1:0] full_addr
);
  logic [MUX_W-1:0] row_q, row_d, col_q, col_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (row_rise) row_d = addr_mux;
    if (col_rise) col_d = addr_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign full_addr = {col_q, row_q};
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import dram_sram_pkg::*;
#(
  parameter int CPU_SLOTS = 2,
  parameter int VID_SLOTS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_cpu,
  input  logic row_lvl,
  input  logic col_lvl,
  input  logic col_rise,
  input  logic region_sel,
  input  logic we_req,
  output logic ce,
  output logic we,
  output logic rd_arm
);
  localparam int CNT_W = $clog2(max_int(CPU_SLOTS, VID_SLOTS) + 1);
  localparam logic [CNT_W-1:0] CPU_LIM = CNT_W'(CPU_SLOTS);
  localparam logic [CNT_W-1:0] VID_LIM = CNT_W'(VID_SLOTS);

  half_e            half_now, half_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base, limit;
  logic             half_chg, grant, is_wr;
  logic             ce_q, ce_d, we_q, we_d, arm_q, arm_d;

  assign half_now = half_cpu ? HALF_CPU : HALF_VID;
  assign half_chg = (half_now != half_q);

  always_comb begin
    cnt_base = half_chg ? '0 : cnt_q;
    limit    = (half_now == HALF_CPU) ? CPU_LIM : VID_LIM;
    grant    = col_rise & row_lvl & ~region_sel & (cnt_base < limit);
    is_wr    = we_req & (half_now == HALF_CPU);
    cnt_d    = grant ? cnt_base + 1'b1 : cnt_base;
    ce_d     = grant | (ce_q & col_lvl);
    we_d     = grant & is_wr;
    arm_d    = grant & ~is_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_VID;
      cnt_q  <= '0;
      ce_q   <= 1'b0;
      we_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      half_q <= half_now;
      cnt_q  <= cnt_d;
      ce_q   <= ce_d;
      we_q   <= we_d;
      arm_q  <= arm_d;
    end
  end

  assign ce     = ce_q;
  assign we     = we_q;
  assign rd_arm = arm_q;
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge #(
  parameter int MUX_W     = 8,
  parameter int DW        = 8,
  parameter int CPU_SLOTS = 2,
  parameter int VID_SLOTS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_cpu,
  input  logic               row_stb,
  input  logic               col_stb,
  input  logic [MUX_W-1:0]   addr_mux,
  input  logic               we_req,
  input  logic               region_sel,
  input  logic [DW-1:0]      sram_rdata,
  output logic [2*MUX_W-1:0] sram_addr,
  output logic               sram_ce,
  output logic               sram_we,
  output logic [DW-1:0]      rd_data
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_core_n;
  logic [1:0]          rise;
  logic                rd_arm;
  logic [DW-1:0]       hold_q, hold_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_core_n = sync_q[SYNC_LEN-1];

  strobe_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_core_n),
    .lvl  ({col_stb, row_stb}),
    .rise (rise)
  );

  addr_demux #(.MUX_W(MUX_W)) u_demux (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .row_rise (rise[0]),
    .col_rise (rise[1]),
    .addr_mux (addr_mux),
    .full_addr(sram_addr)
  );

  slot_ctrl #(.CPU_SLOTS(CPU_SLOTS), .VID_SLOTS(VID_SLOTS)) u_slot (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .half_cpu  (half_cpu),
    .row_lvl   (row_stb),
    .col_lvl   (col_stb),
    .col_rise  (rise[1]),
    .region_sel(region_sel),
    .we_req    (we_req),
    .ce        (sram_ce),
    .we        (sram_we),
    .rd_arm    (rd_arm)
  );

  always_comb begin
    hold_d = hold_q;
    if (rd_arm) hold_d = sram_rdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) hold_q <= '0;
    else             hold_q <= hold_d;
  end

  assign rd_data = hold_q;
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int MUX_W = 8,
  parameter int DW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               half_cpu,
  input logic               row_stb,
  input logic               col_stb,
  input logic               region_sel,
  input logic               sram_ce,
  input logic               sram_we,
  input logic [2*MUX_W-1:0] sram_addr,
  input logic [DW-1:0]      rd_data
);
  // R6
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> sram_ce);

  // R6
  we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> !sram_we);

  // R3
  ce_rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce) |-> ($past(col_stb) && $past(row_stb)));

  // R5
  ce_region_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce) |-> !$past(region_sel));

  // R3
  ce_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ce && col_stb) |=> sram_ce);

  // R4
  ce_needs_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce |-> $past(col_stb));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(sram_ce));

  // R9
  we_cpu_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we) |-> $past(half_cpu));
endmodule

bind dram_sram_bridge bridge_chk #(.MUX_W(MUX_W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_cpu  (half_cpu),
  .row_stb   (row_stb),
  .col_stb   (col_stb),
  .region_sel(region_sel),
  .sram_ce   (sram_ce),
  .sram_we   (sram_we),
  .sram_addr (sram_addr),
  .rd_data   (rd_data)
);

// File: tb/dram_sram_bridge_test.sv
`timescale 1ns/1ps
module dram_sram_bridge_test;
  localparam int MUX_W = 8;
  localparam int DW    = 8;
  localparam int AW    = 2*MUX_W;

  logic clk = 1'b0;
  logic rst_n, half_cpu, row_stb, col_stb, we_req, region_sel;
  logic [MUX_W-1:0] addr_mux;
  logic [DW-1:0]    sram_rdata, wbus;
  logic [AW-1:0]    sram_addr;
  logic             sram_ce, sram_we;
  logic [DW-1:0]    rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mem     [logic [AW-1:0]];
  logic [DW-1:0] ref_mem [logic [AW-1:0]];
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  dram_sram_bridge #(.MUX_W(MUX_W), .DW(DW), .CPU_SLOTS(2), .VID_SLOTS(1)) uut (
    .clk(clk), .rst_n(rst_n), .half_cpu(half_cpu), .row_stb(row_stb),
    .col_stb(col_stb), .addr_mux(addr_mux), .we_req(we_req),
    .region_sel(region_sel), .sram_rdata(sram_rdata), .sram_addr(sram_addr),
    .sram_ce(sram_ce), .sram_we(sram_we), .rd_data(rd_data)
  );

  // SRAM model
  always @(posedge clk) if (sram_ce && sram_we) mem[sram_addr] = wbus;
  always @(negedge clk)
    sram_rdata <= (sram_ce && mem.exists(sram_addr)) ? mem[sram_addr] :
                  (sram_ce ? 8'hFF : 8'h00);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction

  // Monitor: pops expected read data one cycle after a read enable rises
  logic ce_prev = 1'b0;
  bit   pend = 0;
  always @(negedge clk) begin
    if (pend) begin
      pend = 0;
      if (exp_q.size() == 0) check("R7 unexpected read", 32'(rd_data), 32'hDEAD);
      else check("R7 read data", 32'(rd_data), 32'(exp_q.pop_front()));
    end
    if (rst_n && sram_ce && !ce_prev && !sram_we) pend = 1;
    ce_prev = sram_ce;
  end

  task automatic access(input logic [7:0] row, input logic [7:0] col,
                        input logic wr, input logic [7:0] data,
                        input logic sel, input logic exp_grant, input string req);
    logic [AW-1:0] a;
    logic [DW-1:0] rd_before;
    logic          do_wr;
    a = {col, row};
    do_wr = wr && half_cpu;
    rd_before = rd_data;
    row_stb = 1; addr_mux = row; region_sel = sel; we_req = wr;
    @(negedge clk);
    col_stb = 1; addr_mux = col; wbus = data;
    @(negedge clk);
    if (exp_grant) begin
      check({req, " R3 ce"}, 32'(sram_ce), 1);
      check({req, " R2 addr"}, 32'(sram_addr), 32'(a));
      check({req, " R6 we"}, 32'(sram_we), 32'(do_wr));
      if (do_wr) ref_mem[a] = data;
      else exp_q.push_back(ref_rd(a));
    end else begin
      check({req, " ce denied"}, 32'(sram_ce), 0);
    end
    @(negedge clk);
    check({req, " R6 we released"}, 32'(sram_we), 0);
    check({req, " R3 ce held"}, 32'(sram_ce), 32'(exp_grant));
    row_stb = 0; col_stb = 0; we_req = 0; region_sel = 0;
    @(negedge clk);
    check({req, " R3 ce drop"}, 32'(sram_ce), 0);
    if (!exp_grant) check({req, " rd_data kept"}, 32'(rd_data), 32'(rd_before));
  endtask

  task automatic refresh(input logic [7:0] row);
    logic [DW-1:0] rd_before;
    rd_before = rd_data;
    row_stb = 1; addr_mux = row;
    @(negedge clk);
    check("R4 refresh ce", 32'(sram_ce), 0);
    @(negedge clk);
    check("R4 refresh ce late", 32'(sram_ce), 0);
    row_stb = 0;
    @(negedge clk);
    check("R4 refresh rd_data", 32'(rd_data), 32'(rd_before));
  endtask

  task automatic set_half(input logic h);
    half_cpu = h;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; half_cpu = 0; row_stb = 0; col_stb = 0; we_req = 0;
    region_sel = 0; addr_mux = '0; wbus = '0;
    repeat (3) @(negedge clk);
    check("R1 ce in reset", 32'(sram_ce), 0);
    check("R1 we in reset", 32'(sram_we), 0);
    check("R1 rd in reset", 32'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ce after release", 32'(sram_ce), 0);
    repeat (2) @(negedge clk);

    // processor half: two writes, third denied (R8)
    set_half(1);
    access(8'h12, 8'h34, 1, 8'h5A, 0, 1, "R6 write A");
    access(8'h01, 8'h80, 1, 8'hC3, 0, 1, "R6 write B");
    access(8'h12, 8'h34, 0, 8'h00, 0, 0, "R8 third cpu access");

    // video half: read A, second denied (R9)
    set_half(0);
    access(8'h12, 8'h34, 0, 8'h00, 0, 1, "R7 video read A");
    access(8'h01, 8'h80, 0, 8'h00, 0, 0, "R9 second video access");
    refresh(8'h77);

    // next video half: write attempt ignored, served as read (R9), R10 reset
    set_half(1);
    set_half(0);
    access(8'h01, 8'h80, 1, 8'h00, 0, 1, "R9 R10 video write ignored");
    refresh(8'h00);

    // processor half: region suppressed (R5), then two reads still granted
    set_half(1);
    access(8'h01, 8'h80, 0, 8'h00, 1, 0, "R5 region select");
    access(8'h01, 8'h80, 0, 8'h00, 0, 1, "R9 readback B");
    access(8'h12, 8'h34, 0, 8'h00, 0, 1, "R10 readback A");

    // corner addresses
    set_half(0);
    set_half(1);
    access(8'hFF, 8'hFF, 1, 8'h11, 0, 1, "R2 write top");
    access(8'h00, 8'h00, 1, 8'h22, 0, 1, "R2 write bottom");
    set_half(0);
    set_half(1);
    access(8'hFF, 8'hFF, 0, 8'h00, 0, 1, "R2 read top");
    access(8'h00, 8'h00, 0, 8'h00, 0, 1, "R2 read bottom");

    repeat (3) @(negedge clk);
    check("R7 all reads seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule